// File: doc/BRIEF.md
# Bus clock and memory controller for an 8-bit CPU

This block sits between a host and an external 6502-class processor with its SRAM chip. It produces the processor's phase-0 clock one bus cycle at a time. Each bus cycle is one controller clock with phase-0 low, followed by one with phase-0 high. Whenever the processor is not running, phase-0 is held high, so the processor can be parked for as long as needed. During the high phase of each bus cycle, the block turns the processor's address and read/write line into SRAM chip-enable, output-enable and write-enable. A page map can veto that access: a page can be marked as RAM, as read-only, or as unmapped, the last meaning emulated I/O or external hardware.

The host sends commands through a valid/ready port. One command loads the five processor control levels (reset, interrupt, non-maskable interrupt, ready and set-overflow). The others start a free run, run a fixed number of bus cycles, or stop. The clock line is shared with other agents as a wired-OR. During every low phase the block senses the combined line. If another agent is still holding it high, the block abandons the run and records a sticky external-stop flag.

While the processor is parked, the host can drive the SRAM directly, and the processor's bus is ignored.

Top module: `cpu_bus_ctl`

## Requirements
- R1: After reset the block is parked with `phi0_o` high. Whenever it is not running, `phi0_o` stays high. Each bus cycle of a run is exactly one clock with `phi0_o` low, followed by one clock with `phi0_o` high.
- R2: If `phi0_line_i` is high during a clock in which `phi0_o` is low, the next edge parks the block without a high phase and without an SRAM access. That edge also sets `ext_stop_o`, which stays set until a run or step command is accepted.
- R3: In the high phase, `sram_addr_o` equals `cpu_addr_i`. With `cpu_rw_i`=1 the block asserts `sram_ce_o` and `sram_oe_o`; with `cpu_rw_i`=0 it asserts `sram_ce_o` and `sram_we_o`. There is no SRAM access in the low phase, and `sram_we_o` and `sram_oe_o` are never both high.
- R4: The page index is the address with its low 8 bits removed. A kind written with `map_we_i` applies to its page: 00 is RAM (reads and writes), 01 is read-only (writes are suppressed), and 10 or 11 is unmapped (no access). After reset every page is RAM.
- R5: Command op 0 loads `cmd_arg_i[4:0]` as control levels: bit0 reset, bit1 IRQ, bit2 NMI, bit3 ready, bit4 set-overflow. `cpu_lines_o` takes the loaded value one clock after acceptance while parked, and only at the start of the next bus cycle while running. The reset value is 5'b01001.
- R6: Op 2 with count N>0 runs exactly N bus cycles and then parks. Op 2 with N=0 has no effect. `cycles_o` counts bus cycles completed since the last accepted op 1 or op 2.
- R7: Op 1 runs until op 3 arrives. The run then ends at the end of the high phase of the current bus cycle.
- R8: While parked, `host_req_i` performs one SRAM access per clock at `host_addr_i`. `host_we_i`=1 selects a write and 0 selects a read. The processor bus is ignored while parked, and `host_req_i` is ignored while running.
- R9: `cmd_ready_o` is always high for op 0 and op 3. For op 1 and op 2 it is high only while parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command can be taken this clock |
| cmd_op_i | input | 2 | 0 load levels, 1 run, 2 step N, 3 stop |
| cmd_arg_i | input | CNT_W | Level bits or cycle count |
| map_we_i | input | 1 | Write one page map entry |
| map_page_i | input | ADDR_W-8 | Page index to write |
| map_kind_i | input | 2 | Page kind code |
| phi0_o | output | 1 | Own drive of the phase-0 clock |
| phi0_line_i | input | 1 | Sensed wired-OR clock line |
| cpu_addr_i | input | ADDR_W | Processor address |
| cpu_rw_i | input | 1 | Processor read(1)/write(0) |
| cpu_lines_o | output | 5 | Control levels to the processor |
| sram_ce_o | output | 1 | SRAM chip enable |
| sram_oe_o | output | 1 | SRAM output enable |
| sram_we_o | output | 1 | SRAM write enable |
| sram_addr_o | output | ADDR_W | SRAM address |
| host_req_i | input | 1 | Host SRAM access request |
| host_we_i | input | 1 | Host access is a write |
| host_addr_i | input | ADDR_W | Host SRAM address |
| running_o | output | 1 | A run is in progress |
| ext_stop_o | output | 1 | Sticky: last run ended by another agent |
| cycles_o | output | CNT_W | Completed bus cycles |

## Verification
Some rules are checked on every clock:
- the low phase lasts a single clock;
- a sensed high line during the low phase stops the run and sets the flag;
- SRAM strobes appear only in the high phase or for a parked host request, and never with both enables;
- control levels hold steady inside a cycle;
- the counter advances once per high phase;
- the ready rules of R9 hold.

The page-map permissions, exact step counts, the no-effect zero count, the stop timing and the stickiness of the external-stop flag depend on command sequences. Only the bench scenarios, with the scoreboard of expected SRAM accesses, can show those.

// File: rtl/cpu_bus_pkg.sv
package cpu_bus_pkg;
    typedef enum logic [1:0] {
        PH_PARK = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    localparam logic [1:0] OP_LINES = 2'd0;
    localparam logic [1:0] OP_RUN   = 2'd1;
    localparam logic [1:0] OP_STEP  = 2'd2;
    localparam logic [1:0] OP_STOP  = 2'd3;

    localparam logic [1:0] KIND_RAM = 2'b00;
    localparam logic [1:0] KIND_ROM = 2'b01;

    localparam int NLINES = 5;
    // reset asserted, ready asserted, all others idle
    localparam logic [NLINES-1:0] LINES_RST = 5'b01001;
endpackage

// File: rtl/cbc_page_map.sv
module cbc_page_map #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8,
    localparam int IDX_W = ADDR_W - OFS_W,
    localparam int NPAGE = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_page,
    input  logic [1:0]       wr_kind,
    input  logic [IDX_W-1:0] rd_page,
    output logic [1:0]       rd_kind
);
    logic [1:0] kind_d [NPAGE];
    logic [1:0] kind_q [NPAGE];

    always_comb begin
        for (int i = 0; i < NPAGE; i++) begin
            kind_d[i] = kind_q[i];
        end
        if (wr_en) begin
            kind_d[wr_page] = wr_kind;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPAGE; i++) begin
                kind_q[i] <= cpu_bus_pkg::KIND_RAM;
            end
        end else begin
            for (int i = 0; i < NPAGE; i++) begin
                kind_q[i] <= kind_d[i];
            end
        end
    end

    assign rd_kind = kind_q[rd_page];
endmodule

// File: rtl/cbc_sequencer.sv
module cbc_sequencer
    import cpu_bus_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [CNT_W-1:0]  cmd_arg,
    output logic              cmd_ready,
    input  logic              line_sense,
    output phase_e            phase,
    output logic              ext_stop,
    output logic [CNT_W-1:0]  cycles,
    output logic [NLINES-1:0] lines
);
    typedef struct packed {
        phase_e             phase;
        logic               stop_pend;
        logic               counted;
        logic [CNT_W-1:0]   left;
        logic [CNT_W-1:0]   cycles;
        logic               ext_stop;
        logic [NLINES-1:0]  ctrl;
        logic [NLINES-1:0]  lines;
    } seq_t;

    seq_t q, d;
    logic fire;

    always_comb begin
        d         = q;
        cmd_ready = (q.phase == PH_PARK) || (cmd_op == OP_LINES) || (cmd_op == OP_STOP);
        fire      = cmd_valid && cmd_ready;

        if (fire && cmd_op == OP_LINES) begin
            d.ctrl = cmd_arg[NLINES-1:0];
        end

        unique case (q.phase)
            PH_PARK: begin
                d.lines     = q.ctrl;
                d.stop_pend = 1'b0;
                if (fire && (cmd_op == OP_RUN ||
                             (cmd_op == OP_STEP && cmd_arg != '0))) begin
                    d.phase    = PH_LOW;
                    d.counted  = (cmd_op == OP_STEP);
                    d.left     = cmd_arg;
                    d.cycles   = '0;
                    d.ext_stop = 1'b0;
                end
            end
            PH_LOW: begin
                if (fire && cmd_op == OP_STOP) d.stop_pend = 1'b1;
                if (line_sense) begin
                    d.phase    = PH_PARK;
                    d.ext_stop = 1'b1;
                end else begin
                    d.phase = PH_HIGH;
                end
            end
            PH_HIGH: begin
                d.cycles = q.cycles + 1'b1;
                if (q.counted) d.left = q.left - 1'b1;
                if (q.stop_pend || (fire && cmd_op == OP_STOP) ||
                    (q.counted && q.left == CNT_W'(1))) begin
                    d.phase = PH_PARK;
                end else begin
                    d.phase = PH_LOW;
                    d.lines = q.ctrl;
                end
            end
            default: d.phase = PH_PARK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase     <= PH_PARK;
            q.stop_pend <= 1'b0;
            q.counted   <= 1'b0;
            q.left      <= '0;
            q.cycles    <= '0;
            q.ext_stop  <= 1'b0;
            q.ctrl      <= LINES_RST;
            q.lines     <= LINES_RST;
        end else begin
            q <= d;
        end
    end

    assign phase    = q.phase;
    assign ext_stop = q.ext_stop;
    assign cycles   = q.cycles;
    assign lines    = q.lines;
endmodule

// File: rtl/cbc_sram_path.sv
module cbc_sram_path
    import cpu_bus_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  phase_e            phase,
    input  logic              cpu_rw,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        page_kind,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              ce,
    output logic              oe,
    output logic              we,
    output logic [ADDR_W-1:0] addr
);
    logic rd_ok, wr_ok;

    always_comb begin
        rd_ok = (page_kind == KIND_RAM) || (page_kind == KIND_ROM);
        wr_ok = (page_kind == KIND_RAM);
        ce    = 1'b0;
        oe    = 1'b0;
        we    = 1'b0;
        addr  = cpu_addr;
        if (phase == PH_PARK) begin
            addr = host_addr;
            ce   = host_req;
            we   = host_req && host_we;
            oe   = host_req && !host_we;
        end else if (phase == PH_HIGH) begin
            oe = cpu_rw && rd_ok;
            we = !cpu_rw && wr_ok;
            ce = oe || we;
        end
    end
endmodule

// File: rtl/cpu_bus_ctl.sv
module cpu_bus_ctl
    import cpu_bus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    localparam int OFS_W  = 8,
    localparam int PAGE_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic [1:0]        cmd_op_i,
    input  logic [CNT_W-1:0]  cmd_arg_i,
    input  logic              map_we_i,
    input  logic [PAGE_W-1:0] map_page_i,
    input  logic [1:0]        map_kind_i,
    output logic              phi0_o,
    input  logic              phi0_line_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic              cpu_rw_i,
    output logic [4:0]        cpu_lines_o,
    output logic              sram_ce_o,
    output logic              sram_oe_o,
    output logic              sram_we_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    input  logic              host_req_i,
    input  logic              host_we_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    output logic              running_o,
    output logic              ext_stop_o,
    output logic [CNT_W-1:0]  cycles_o
);
    phase_e     phase;
    logic [1:0] page_kind;

    cbc_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid_i),
        .cmd_op     (cmd_op_i),
        .cmd_arg    (cmd_arg_i),
        .cmd_ready  (cmd_ready_o),
        .line_sense (phi0_line_i),
        .phase      (phase),
        .ext_stop   (ext_stop_o),
        .cycles     (cycles_o),
        .lines      (cpu_lines_o)
    );

    cbc_page_map #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (map_we_i),
        .wr_page (map_page_i),
        .wr_kind (map_kind_i),
        .rd_page (cpu_addr_i[ADDR_W-1:OFS_W]),
        .rd_kind (page_kind)
    );

    cbc_sram_path #(.ADDR_W(ADDR_W)) u_path (
        .phase     (phase),
        .cpu_rw    (cpu_rw_i),
        .cpu_addr  (cpu_addr_i),
        .page_kind (page_kind),
        .host_req  (host_req_i),
        .host_we   (host_we_i),
        .host_addr (host_addr_i),
        .ce        (sram_ce_o),
        .oe        (sram_oe_o),
        .we        (sram_we_o),
        .addr      (sram_addr_o)
    );

    assign phi0_o    = (phase != PH_LOW);
    assign running_o = (phase != PH_PARK);
endmodule

// File: rtl/cpu_bus_ctl_chk.sv
module cpu_bus_ctl_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready_o,
    input logic [1:0]        cmd_op_i,
    input logic              phi0_o,
    input logic              phi0_line_i,
    input logic [ADDR_W-1:0] cpu_addr_i,
    input logic [4:0]        cpu_lines_o,
    input logic              sram_ce_o,
    input logic              sram_oe_o,
    input logic              sram_we_o,
    input logic [ADDR_W-1:0] sram_addr_o,
    input logic              host_req_i,
    input logic              running_o,
    input logic              ext_stop_o,
    input logic [CNT_W-1:0]  cycles_o
);
    p_low_one_clock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !phi0_o |=> phi0_o);

    p_parked_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running_o) |-> phi0_o);

    p_hold_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!phi0_o && phi0_line_i) |=> (!running_o && ext_stop_o));

    p_no_low_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && sram_ce_o) |-> (phi0_o && sram_addr_o == cpu_addr_i));

    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_we_o && sram_oe_o) && ((sram_we_o || sram_oe_o) == sram_ce_o));

    p_lines_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && phi0_o) |-> $stable(cpu_lines_o));

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && phi0_o) |=> (cycles_o == $past(cycles_o) + 1'b1));

    p_parked_host_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && sram_ce_o) |-> host_req_i);

    p_ready_rule_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && cmd_ready_o) |-> (cmd_op_i == 2'd0 || cmd_op_i == 2'd3));
endmodule

bind cpu_bus_ctl cpu_bus_ctl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/cpu_bus_ctl_test.sv
module cpu_bus_ctl_test;
    localparam int PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid_i = 1'b0;
    logic              cmd_ready_o;
    logic [1:0]        cmd_op_i = 2'd0;
    logic [CNT_W-1:0]  cmd_arg_i = '0;
    logic              map_we_i = 1'b0;
    logic [7:0]        map_page_i = '0;
    logic [1:0]        map_kind_i = '0;
    logic              phi0_o;
    logic              phi0_line_i;
    logic              ext_hold = 1'b0;
    logic [ADDR_W-1:0] cpu_addr_i = '0;
    logic              cpu_rw_i = 1'b1;
    logic [4:0]        cpu_lines_o;
    logic              sram_ce_o, sram_oe_o, sram_we_o;
    logic [ADDR_W-1:0] sram_addr_o;
    logic              host_req_i = 1'b0;
    logic              host_we_i = 1'b0;
    logic [ADDR_W-1:0] host_addr_i = '0;
    logic              running_o, ext_stop_o;
    logic [CNT_W-1:0]  cycles_o;

    int checks = 0;
    int fails  = 0;
    logic [17:0] exp_q[$];

    assign phi0_line_i = phi0_o | ext_hold;

    always #(PERIOD/2) clk = ~clk;

    cpu_bus_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] op, input logic [CNT_W-1:0] arg);
        @(posedge clk); #1;
        cmd_valid_i = 1'b1; cmd_op_i = op; cmd_arg_i = arg;
        while (!cmd_ready_o) begin @(posedge clk); #1; end
        @(posedge clk); #1;
        cmd_valid_i = 1'b0;
    endtask

    task automatic set_page(input logic [7:0] pg, input logic [1:0] kind);
        @(posedge clk); #1;
        map_we_i = 1'b1; map_page_i = pg; map_kind_i = kind;
        @(posedge clk); #1;
        map_we_i = 1'b0;
    endtask

    task automatic wait_park(output int lows);
        int guard = 0;
        lows = 0;
        do begin
            @(negedge clk);
            if (!phi0_o) lows++;
            guard++;
        end while (running_o && guard < 1000);
    endtask

    // one single-cycle step with given processor bus, optionally expecting one access
    task automatic one_cycle(input logic [15:0] a, input logic rw, input bit hit, input string req);
        int lows;
        @(posedge clk); #1;
        cpu_addr_i = a; cpu_rw_i = rw;
        if (hit) exp_q.push_back({!rw, rw, a});
        send(2'd2, 16'd1);
        wait_park(lows);
        check(lows == 1 && cycles_o == 16'd1, req, cycles_o, 1);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && sram_ce_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R4/R8 unexpected SRAM access", {sram_we_o, sram_oe_o, sram_addr_o}, 0);
            end else begin
                logic [17:0] e;
                e = exp_q.pop_front();
                check({sram_we_o, sram_oe_o, sram_addr_o} == e, "R3/R4/R8 access",
                      {sram_we_o, sram_oe_o, sram_addr_o}, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int lows;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(phi0_o && !running_o, "R1 reset parked high", phi0_o, 1);
        check(cpu_lines_o == 5'b01001, "R5 reset levels", cpu_lines_o, 5'b01001);
        check(!ext_stop_o && cycles_o == 0 && !sram_ce_o, "R2 reset flags", ext_stop_o, 0);
        check(cmd_ready_o, "R9 ready when parked", cmd_ready_o, 1);

        // R5 load levels while parked: visible one clock after acceptance
        send(2'd0, 16'h0016);
        @(negedge clk);
        check(cpu_lines_o == 5'b01001, "R5 levels not yet", cpu_lines_o, 5'b01001);
        @(negedge clk);
        check(cpu_lines_o == 5'b10110, "R5 levels loaded", cpu_lines_o, 5'b10110);

        // R4 page map set-up
        set_page(8'h20, 2'b01);
        set_page(8'h30, 2'b10);
        set_page(8'h31, 2'b11);

        // R3 R4 single-cycle accesses
        one_cycle(16'h1234, 1'b1, 1'b1, "R3 ram read step");
        one_cycle(16'h1240, 1'b0, 1'b1, "R3 ram write step");
        one_cycle(16'h2005, 1'b1, 1'b1, "R4 rom read step");
        one_cycle(16'h2006, 1'b0, 1'b0, "R4 rom write suppressed");
        one_cycle(16'h3000, 1'b1, 1'b0, "R4 unmapped read suppressed");
        one_cycle(16'h31FF, 1'b0, 1'b0, "R4 unmapped write suppressed");
        check(exp_q.size() == 0, "R4 all expected accesses seen", exp_q.size(), 0);

        // R6 step of three
        @(posedge clk); #1 cpu_addr_i = 16'h3010; cpu_rw_i = 1'b1;
        send(2'd2, 16'd3);
        wait_park(lows);
        check(lows == 3, "R6 three low phases", lows, 3);
        check(cycles_o == 16'd3 && phi0_o, "R6 count three", cycles_o, 3);

        // R6 zero count has no effect
        send(2'd2, 16'd0);
        @(negedge clk);
        check(!running_o && cycles_o == 16'd3, "R6 zero step ignored", cycles_o, 3);

        // R8 host access while parked, processor bus ignored
        @(posedge clk); #1;
        cpu_addr_i = 16'h1000; cpu_rw_i = 1'b0;
        host_req_i = 1'b1; host_we_i = 1'b1; host_addr_i = 16'h0077;
        exp_q.push_back({1'b1, 1'b0, 16'h0077});
        @(posedge clk); #1;
        host_we_i = 1'b0; host_addr_i = 16'h2080;
        exp_q.push_back({1'b0, 1'b1, 16'h2080});
        @(posedge clk); #1;
        host_req_i = 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0, "R8 host accesses", exp_q.size(), 0);

        // R7 free run on unmapped page, host ignored, R9 ready rules
        cpu_addr_i = 16'h3044; cpu_rw_i = 1'b1;
        send(2'd1, 16'd0);
        host_req_i = 1'b1; host_we_i = 1'b1; host_addr_i = 16'h0100;
        cmd_op_i = 2'd1;
        repeat (20) @(negedge clk);
        check(running_o && cycles_o >= 16'd9, "R7 free run continues", cycles_o, 9);
        check(!cmd_ready_o, "R9 run not ready while running", cmd_ready_o, 0);
        @(posedge clk); #1 cmd_op_i = 2'd0;
        @(negedge clk);
        check(cmd_ready_o, "R9 levels ready while running", cmd_ready_o, 1);
        @(posedge clk); #1 host_req_i = 1'b0;
        send(2'd3, 16'd0);
        repeat (3) @(negedge clk);
        check(!running_o && phi0_o && !ext_stop_o, "R7 stop parks high", running_o, 0);

        // R2 stop requested by another agent through the shared line
        send(2'd1, 16'd0);
        repeat (5) @(negedge clk);
        @(posedge clk); #1 ext_hold = 1'b1;
        repeat (3) @(negedge clk);
        check(!running_o && ext_stop_o, "R2 hold stops run", {running_o, ext_stop_o}, 1);
        @(posedge clk); #1 ext_hold = 1'b0;
        repeat (3) @(negedge clk);
        check(ext_stop_o && phi0_o && !running_o, "R2 flag sticky", ext_stop_o, 1);
        send(2'd2, 16'd2);
        @(negedge clk);
        check(!ext_stop_o, "R2 flag cleared by step", ext_stop_o, 0);
        wait_park(lows);
        check(cycles_o == 16'd2, "R6 two cycles", cycles_o, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule